// File: doc/BRIEF.md
# Replicated Register Steering Fabric

This block models one register address that is backed by a grid of physical copies, organised as groups each holding several instances. A steering selector register chooses a group, an instance and whether data writes are broadcast or targeted. A broadcast write stores the same value in every copy that is present and powered. A targeted write stores it in the one selected copy. A data read always returns the one selected copy. Two mask inputs mark copies as fused off or power-gated. Accesses that land on such a copy are dropped without any fault: reads give zero and targeted writes vanish.

Two agents, a host and a firmware controller, share the selector. They coordinate through a semaphore register in the same small register window. A read of the semaphore that returns 1 takes ownership. The owner gives it back by writing 1. After any targeted data write, the selector flips back to broadcast mode by itself, so it rests in broadcast mode between operations.

Every request on the register port is a single cycle. A read answers with a registered response one cycle later.

Top module: `steer_fabric`

## Requirements
- R1: After reset every copy holds zero, the semaphore is free, and the selector holds group 0, instance 0 with the broadcast bit set, so it reads back as 0x0001_0000.
- R2: A read request produces `rsp_valid` high in exactly the next cycle, with the data in `rsp_rdata`. A write request produces no response.
- R3: The selector word places the instance ID in bits [INST_W-1:0], the group ID in bits [8 +: GRP_W] and the broadcast bit at bit 16. A read returns the stored fields with all other bits zero.
- R4: A data write with the broadcast bit set stores the value in every live copy, where live means both present and powered. Copies that are fused off or gated keep their old value.
- R5: A data write with the broadcast bit clear stores the value only in the copy at index group*NUM_INST+instance. If that copy is not live, the write is discarded.
- R6: A data read returns the selected copy whatever the broadcast bit holds. It returns zero when that copy is fused off or gated, and the stored value is still there once the copy is live again.
- R7: After a targeted data write, the selector's broadcast bit is set again and its group and instance fields are kept.
- R8: A semaphore read while the semaphore is free returns 1 and makes the reading agent (`req_agent`: 0 host, 1 firmware) the owner.
- R9: A semaphore read while it is held returns 0, even for the owner. A write with bit 0 set by the owner frees it. The same write from the other agent, or any write with bit 0 clear, has no effect.
- R10: Register offsets are 0 for data, 1 for the selector and 2 for the semaphore. Any other offset reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register offset |
| req_agent | input | 1 | Requesting agent: 0 host, 1 firmware |
| req_wdata | input | DATA_W | Write data |
| copy_present | input | NUM_GROUPS*NUM_INST | Per-copy present flag (0 = fused off) |
| copy_powered | input | NUM_GROUPS*NUM_INST | Per-copy power flag (0 = gated) |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | DATA_W | Read response data |

## Verification
Read data, including the semaphore grant value, is due one clock after the request. Writes to the copies, the selector and the semaphore state take effect at that same edge, so the next request already sees them. The bench drives each request on a falling edge and samples the response on the following falling edge, which falls after the one registering edge. Copy contents are observed only through later steered reads, after the masks have been set to make the copy live.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int SEL_GRP_LSB = 8;
  localparam int SEL_MC_BIT  = 16;

  typedef enum logic [1:0] {
    RS_DATA = 2'd0,
    RS_SEL  = 2'd1,
    RS_SEM  = 2'd2,
    RS_NONE = 2'd3
  } reg_sel_e;

  // Flat copy index of a (group, instance) pair.
  function automatic int copy_index(input int grp, input int inst, input int n_inst);
    return grp * n_inst + inst;
  endfunction

  // Offset decode of the register window.
  function automatic reg_sel_e decode_offset(input int unsigned off);
    case (off)
      0:       return RS_DATA;
      1:       return RS_SEL;
      2:       return RS_SEM;
      default: return RS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/steer_decode.sv
module steer_decode #(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_INST   = 4,
  parameter int GRP_W      = 2,
  parameter int INST_W     = 2,
  localparam int NCOPY     = NUM_GROUPS * NUM_INST
) (
  input  logic [GRP_W-1:0]  sel_grp,
  input  logic [INST_W-1:0] sel_inst,
  input  logic [NCOPY-1:0]  live,
  output logic [NCOPY-1:0]  tgt_onehot,
  output logic              tgt_live
);
  import steer_pkg::*;

  int tgt_idx;
  assign tgt_idx = copy_index(int'(sel_grp), int'(sel_inst), NUM_INST);

  for (genvar k = 0; k < NCOPY; k++) begin : g_tgt
    assign tgt_onehot[k] = (tgt_idx == k);
  end

  assign tgt_live = |(tgt_onehot & live);
endmodule

// File: rtl/copy_bank.sv
module copy_bank #(
  parameter int NCOPY  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCOPY-1:0]  we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCOPY-1:0]  rd_onehot,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] copies [NCOPY];

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    always_ff @(posedge clk) begin
      if (!rst_n)     copies[k] <= '0;
      else if (we[k]) copies[k] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NCOPY; k++)
      if (rd_onehot[k]) rdata = rdata | copies[k];
  end
endmodule

// File: rtl/sem_unit.sv
module sem_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic wr_req,
  input  logic agent,
  input  logic wbit,
  output logic grant,
  output logic release_ev,
  output logic held,
  output logic owner
);
  assign grant      = rd_req && !held;
  assign release_ev = wr_req && held && wbit && (agent == owner);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= 1'b0;
      owner <= 1'b0;
    end else if (grant) begin
      held  <= 1'b1;
      owner <= agent;
    end else if (release_ev) begin
      held  <= 1'b0;
    end
  end
endmodule

// File: rtl/steer_fabric.sv
module steer_fabric #(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_INST   = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  localparam int NCOPY     = NUM_GROUPS * NUM_INST,
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int INST_W    = (NUM_INST > 1) ? $clog2(NUM_INST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_agent,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NCOPY-1:0]  copy_present,
  input  logic [NCOPY-1:0]  copy_powered,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  import steer_pkg::*;

  reg_sel_e          rsel;
  logic              wr_data_hit, rd_data_hit, wr_sel_hit, rd_sem_hit, wr_sem_hit;
  logic [GRP_W-1:0]  sel_grp;
  logic [INST_W-1:0] sel_inst;
  logic              sel_mc;
  logic [NCOPY-1:0]  live, tgt_onehot, copy_we;
  logic              tgt_live;
  logic [DATA_W-1:0] bank_rdata, sel_word, rdata_d;
  logic              sem_grant, sem_release, sem_held, sem_owner;

  assign rsel        = decode_offset(int'(req_addr));
  assign wr_data_hit = req_valid &&  req_write && (rsel == RS_DATA);
  assign rd_data_hit = req_valid && !req_write && (rsel == RS_DATA);
  assign wr_sel_hit  = req_valid &&  req_write && (rsel == RS_SEL);
  assign rd_sem_hit  = req_valid && !req_write && (rsel == RS_SEM);
  assign wr_sem_hit  = req_valid &&  req_write && (rsel == RS_SEM);
  assign live        = copy_present & copy_powered;

  steer_decode #(.NUM_GROUPS(NUM_GROUPS), .NUM_INST(NUM_INST),
                 .GRP_W(GRP_W), .INST_W(INST_W)) u_decode (
    .sel_grp(sel_grp), .sel_inst(sel_inst), .live(live),
    .tgt_onehot(tgt_onehot), .tgt_live(tgt_live)
  );

  // Broadcast hits every live copy, targeted hits the selected live copy.
  assign copy_we = !wr_data_hit ? '0 : (sel_mc ? live : (tgt_onehot & live));

  copy_bank #(.NCOPY(NCOPY), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(copy_we), .wdata(req_wdata),
    .rd_onehot(tgt_onehot), .rdata(bank_rdata)
  );

  sem_unit u_sem (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_sem_hit), .wr_req(wr_sem_hit),
    .agent(req_agent), .wbit(req_wdata[0]),
    .grant(sem_grant), .release_ev(sem_release),
    .held(sem_held), .owner(sem_owner)
  );

  // Selector register; a targeted data write restores broadcast mode.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_grp  <= '0;
      sel_inst <= '0;
      sel_mc   <= 1'b1;
    end else if (wr_sel_hit) begin
      sel_grp  <= req_wdata[SEL_GRP_LSB +: GRP_W];
      sel_inst <= req_wdata[INST_W-1:0];
      sel_mc   <= req_wdata[SEL_MC_BIT];
    end else if (wr_data_hit && !sel_mc) begin
      sel_mc   <= 1'b1;
    end
  end

  always_comb begin
    sel_word = '0;
    sel_word[SEL_GRP_LSB +: GRP_W] = sel_grp;
    sel_word[INST_W-1:0]           = sel_inst;
    sel_word[SEL_MC_BIT]           = sel_mc;
  end

  always_comb begin
    rdata_d = '0;
    case (rsel)
      RS_DATA: rdata_d = tgt_live ? bank_rdata : '0;
      RS_SEL:  rdata_d = sel_word;
      RS_SEM:  rdata_d[0] = sem_grant;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rdata_d : '0;
    end
  end
endmodule

// File: rtl/steer_fabric_checker.sv
module steer_fabric_checker #(
  parameter int NCOPY  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              wr_data_hit,
  input logic              rd_sem_hit,
  input logic              sem_held,
  input logic              sel_mc,
  input logic [NCOPY-1:0]  copy_we,
  input logic [NCOPY-1:0]  live,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata
);
  a_r2_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  a_r4_live_only: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_hit |-> ((copy_we & ~live) == '0));
  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_hit && !sel_mc) |-> $onehot0(copy_we));
  a_r7_mc_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_hit && !sel_mc) |=> sel_mc);
  a_r8_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sem_hit && !sem_held) |=> (sem_held && rsp_rdata == DATA_W'(1)));
  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sem_hit && sem_held) |=> (sem_held && rsp_rdata == '0));
endmodule

bind steer_fabric steer_fabric_checker #(.NCOPY(NCOPY), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .wr_data_hit(wr_data_hit), .rd_sem_hit(rd_sem_hit), .sem_held(sem_held),
  .sel_mc(sel_mc), .copy_we(copy_we), .live(live),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
);

// File: tb/steer_fabric_bench.sv
module steer_fabric_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 4, NI = 4, NC = NG * NI, DW = 32, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_agent = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NC-1:0] copy_present = '1, copy_powered = '1;
  logic rsp_valid;
  logic [DW-1:0] rsp_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // Bench-side model
  logic [DW-1:0] m_copy [NC];
  int m_grp = 0, m_inst = 0;
  bit m_mc = 1'b1, m_held = 1'b0, m_owner = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  steer_fabric #(.NUM_GROUPS(NG), .NUM_INST(NI), .DATA_W(DW), .ADDR_W(AW)) u_steer_fabric (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_agent(req_agent), .req_wdata(req_wdata),
    .copy_present(copy_present), .copy_powered(copy_powered),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [DW-1:0] sel_word(int g, int i, bit mc);
    return (DW'(mc) << 16) | (DW'(g) << 8) | DW'(i);
  endfunction

  function automatic bit is_live(int idx);
    return copy_present[idx] && copy_powered[idx];
  endfunction

  task automatic check(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(bit wr, int a, bit ag, logic [DW-1:0] d,
                     output logic [DW-1:0] rd, output bit rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_agent = ag; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd = rsp_rdata; rv = rsp_valid;
  endtask

  // Model-tracking operations
  task automatic wr_sel(int g, int i, bit mc);
    logic [DW-1:0] rd; bit rv;
    bus(1, 1, 0, sel_word(g, i, mc), rd, rv);
    m_grp = g; m_inst = i; m_mc = mc;
  endtask

  task automatic wr_data(logic [DW-1:0] v);
    logic [DW-1:0] rd; bit rv;
    int idx = m_grp * NI + m_inst;
    if (m_mc) begin
      for (int k = 0; k < NC; k++) if (is_live(k)) m_copy[k] = v;
    end else if (is_live(idx)) m_copy[idx] = v;
    bus(1, 0, 0, v, rd, rv);
    m_mc = 1'b1;
  endtask

  task automatic rd_data_chk(string req);
    logic [DW-1:0] rd; bit rv;
    int idx = m_grp * NI + m_inst;
    logic [DW-1:0] exp = is_live(idx) ? m_copy[idx] : '0;
    bus(0, 0, 0, '0, rd, rv);
    check(rv && rd == exp, req, rd, exp);
  endtask

  task automatic sem_rd_chk(bit ag, string req);
    logic [DW-1:0] rd; bit rv;
    logic [DW-1:0] exp = m_held ? '0 : DW'(1);
    if (!m_held) begin m_held = 1'b1; m_owner = ag; end
    bus(0, 2, ag, '0, rd, rv);
    check(rv && rd == exp, req, rd, exp);
  endtask

  task automatic sem_wr(bit ag, logic [DW-1:0] v);
    logic [DW-1:0] rd; bit rv;
    if (m_held && v[0] && ag == m_owner) m_held = 1'b0;
    bus(1, 2, ag, v, rd, rv);
  endtask

  // Read every copy with all copies live; mode bit of the selector varied.
  task automatic sweep(string req);
    logic [NC-1:0] sp = copy_present, sw = copy_powered;
    copy_present = '1; copy_powered = '1;
    for (int g = 0; g < NG; g++)
      for (int i = 0; i < NI; i++) begin
        wr_sel(g, i, (g + i) % 2 == 0);
        rd_data_chk(req);
      end
    copy_present = sp; copy_powered = sw;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rd; bit rv;
    void'($urandom(32'd1234));
    for (int k = 0; k < NC; k++) m_copy[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    bus(0, 1, 0, '0, rd, rv);
    check(rv && rd == 32'h0001_0000, "R1 selector reset", rd, 32'h0001_0000);
    sweep("R1 copies zero");

    // R2: write gives no response
    bus(1, 1, 0, sel_word(0, 0, 1), rd, rv);
    check(!rv, "R2 no write response", DW'(rv), 0);

    // R3: field layout, unused bits dropped
    bus(1, 1, 0, 32'hFFFF_FFFF, rd, rv);
    m_grp = 3; m_inst = 3; m_mc = 1'b1;
    bus(0, 1, 0, '0, rd, rv);
    check(rd == 32'h0001_0303, "R3 selector fields", rd, 32'h0001_0303);

    // R4: broadcast skips fused copy 5 and gated copy 9
    copy_present[5] = 1'b0; copy_powered[9] = 1'b0;
    wr_sel(1, 2, 1);
    wr_data(32'hA5A5_0001);
    copy_present = '1; copy_powered = '1;
    sweep("R4 broadcast");

    // R5: targeted write to live copy 6, then to fused copy 2
    wr_sel(1, 2, 0); wr_data(32'h0000_1234);
    copy_present[2] = 1'b0;
    wr_sel(0, 2, 0); wr_data(32'hDEAD_BEEF);
    copy_present = '1;
    sweep("R5 targeted");

    // R7: broadcast bit restored, fields kept
    wr_sel(2, 1, 0); wr_data(32'h7777_0000);
    bus(0, 1, 0, '0, rd, rv);
    check(rd == sel_word(2, 1, 1), "R7 mode restore", rd, sel_word(2, 1, 1));

    // R6: read ignores mode bit, gated copy reads zero then reappears
    wr_sel(1, 2, 0); rd_data_chk("R6 targeted-mode read");
    wr_sel(1, 2, 1); rd_data_chk("R6 broadcast-mode read");
    copy_powered[6] = 1'b0; rd_data_chk("R6 gated read zero");
    copy_powered[6] = 1'b1; rd_data_chk("R6 value kept");

    // R8/R9: semaphore
    sem_rd_chk(0, "R8 host grant");
    sem_rd_chk(1, "R9 busy for firmware");
    sem_rd_chk(0, "R9 busy for owner");
    sem_wr(1, 32'h1); sem_rd_chk(1, "R9 foreign release ignored");
    sem_wr(0, 32'h0); sem_rd_chk(1, "R9 zero write ignored");
    sem_wr(0, 32'h1); sem_rd_chk(1, "R8 firmware grant after release");
    sem_wr(0, 32'h1); sem_rd_chk(0, "R9 host cannot release firmware hold");
    sem_wr(1, 32'h1); sem_rd_chk(0, "R8 host regrant");
    sem_wr(0, 32'h1);

    // R10: unmapped offsets
    bus(0, 3, 0, '0, rd, rv);
    check(rv && rd == '0, "R10 unmapped read", rd, 0);
    bus(1, 5, 0, 32'hFFFF_FFFF, rd, rv);
    bus(1, 15, 0, 32'h0, rd, rv);
    bus(0, 1, 0, '0, rd, rv);
    check(rd == sel_word(m_grp, m_inst, m_mc), "R10 selector untouched", rd,
          sel_word(m_grp, m_inst, m_mc));
    sweep("R10 copies untouched");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 5);
      if ($urandom_range(0, 7) == 0) begin
        copy_present = NC'($urandom | $urandom);
        copy_powered = NC'($urandom | $urandom);
      end
      case (op)
        0: wr_sel($urandom_range(0, NG-1), $urandom_range(0, NI-1), $urandom_range(0, 1));
        1, 2: wr_data($urandom);
        3: rd_data_chk("R6 random read");
        4: sem_rd_chk($urandom_range(0, 1), "R9 random semaphore");
        default: sem_wr($urandom_range(0, 1), DW'($urandom_range(0, 1)));
      endcase
    end
    copy_present = '1; copy_powered = '1;
    sweep("R4 R5 random final");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule